// File: doc/BRIEF.md
# Operand Field Decoder for 16-bit Real-Mode Instructions

This block looks at the two leading bytes of a 16-bit real-mode instruction, together with the two bytes that may follow them. The first byte carries a six-bit opcode, a direction-or-sign bit and a width bit. The second byte carries a two-bit addressing mode, a three-bit register field and a three-bit register/memory field. From these fields the block works out which registers are read and written, and how each one maps onto the physical register file once byte halves are taken into account. It also reports whether one operand sits in memory and how many displacement and immediate bytes follow. When there is a memory operand, it forms the 16-bit effective address from the base and index register values and the displacement that are supplied to it.

The caller fills in the stimulus and raises `in_valid`. Two side-band inputs say whether the instruction uses bit 1 of the first byte as a sign-extend flag (`s_used`) and whether an immediate follows the displacement (`imm_present`). All results are registered on the strobe, appear one cycle later and hold until the next strobe. Fetching bytes, segment arithmetic and execution are handled elsewhere.

Top module: `opdec_top`

## Requirements
- R1: While reset is high, and after it until the first strobe, every output is zero.
- R2: Each output takes the value decoded from the inputs sampled at the rising edge where `in_valid` is 1. It is visible after that edge, and `out_valid` is 1 for exactly that cycle. When `in_valid` is 0 the outputs hold their values, whatever the other inputs do.
- R3: Field positions: first byte bit 0 = W, bit 1 = D (or S), bits 7:2 = opcode (on `out_opcode`). Second byte bits 7:6 = mode, 5:3 = register field, 2:0 = register/memory field. When `s_used`=0 and D=1, the register field is the destination and the register/memory field is the source. When D=0 these roles swap.
- R4: A register code c maps to a slot (index, high) as follows. With W=1 the slot is (c, 0). With W=0 the slot is (c mod 4, c div 4), so codes 4..7 name the upper byte of registers 0..3. `op_wide` reports W. With W=1 both high outputs are 0.
- R5: Mode 11 is register mode: `mem_operand`=0, `eff_addr`=0 and there are no displacement bytes. In modes 00, 01 and 10, `mem_operand`=1 and the slot of the memory operand reads index 0, high 0.
- R6: The memory address is formed by register/memory field as follows: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. The displacement is added to this, and the sum wraps modulo 65536.
- R7: Mode 00 adds no displacement. Mode 01 adds the low displacement byte sign-extended to 16 bits and counts 1 byte. Mode 10 adds {high byte, low byte} and counts 2 bytes.
- R8: Mode 00 with register/memory field 110 is a direct address equal to {high byte, low byte} and counts 2 displacement bytes.
- R9: With `s_used`=1, the register field is an opcode extension. The destination slot is the register/memory operand and the source slot is (0,0). `imm_sext` is 1 exactly when S=1 and W=1.
- R10: `bad_combo` is 1 exactly when `s_used`=1, S=1 and W=0.
- R11: `byte_count` = displacement bytes + immediate bytes. With `imm_present`=0 the immediate counts 0 bytes. With `s_used`=1 it counts 2 bytes only for S=0,W=1 and 1 byte otherwise. With `s_used`=0 it counts 2 bytes for W=1 and 1 byte for W=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode strobe |
| op_byte | input | 8 | First instruction byte |
| modrm_byte | input | 8 | Second instruction byte |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| s_used | input | 1 | Bit 1 of the first byte is a sign-extend flag |
| imm_present | input | 1 | An immediate follows the displacement |
| bx_val | input | 16 | BX value |
| bp_val | input | 16 | BP value |
| si_val | input | 16 | SI value |
| di_val | input | 16 | DI value |
| out_valid | output | 1 | Results updated this cycle |
| out_opcode | output | 6 | Opcode field |
| op_wide | output | 1 | Word operation |
| src_idx | output | 3 | Source register index |
| src_hi | output | 1 | Source is the upper byte |
| dst_idx | output | 3 | Destination register index |
| dst_hi | output | 1 | Destination is the upper byte |
| mem_operand | output | 1 | One operand is in memory |
| eff_addr | output | 16 | Effective address |
| byte_count | output | 3 | Displacement plus immediate bytes |
| bad_combo | output | 1 | Invalid sign/width combination |
| imm_sext | output | 1 | Short immediate is sign-extended |

## Verification
The bench goes after the corner cases that a small slip would break.

- **Byte aliasing of codes 4..7.** A decoder that skips the alias would report index 4..7 with the high flag clear, writing a pointer register instead of AH..BH.
- **Direct address under mode 00, field 110.** Omitting this exception would add BP and count no displacement bytes.
- **Negative short displacement and wrap-around sums.** These show a zero-extended displacement as an address off by 256, and a carry that leaks into the result.
- **The sign/width combinations.** These show whether the immediate count, the sign-extend flag and the invalid flag are swapped or missed.
- **Strobe-free cycles with changing inputs.** These catch outputs that track their inputs instead of holding.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int CODE_W  = 3;
    localparam int MODE_W  = 2;
    localparam int OPC_W   = BYTE_W - 2;
    localparam int CNT_W   = 3;
    localparam int NREG_B  = 4;  // registers that own two byte halves

    localparam logic [MODE_W-1:0] MODE_NODISP = 2'b00;
    localparam logic [MODE_W-1:0] MODE_DISP8  = 2'b01;
    localparam logic [MODE_W-1:0] MODE_DISP16 = 2'b10;
    localparam logic [MODE_W-1:0] MODE_REG    = 2'b11;
    localparam logic [CODE_W-1:0] RM_DIRECT   = 3'b110;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic             dirs;   // direction, or sign-extend when used
        logic             wide;
    } lead_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CODE_W-1:0] regf;
        logic [CODE_W-1:0] rmf;
    } modrm_t;

    typedef struct packed {
        logic [CODE_W-1:0] idx;
        logic              hi;
    } slot_t;

    // Resolve a register code to a physical slot under the width bit.
    function automatic slot_t map_code(input logic [CODE_W-1:0] code, input logic wide);
        slot_t s;
        if (wide) begin
            s.idx = code;
            s.hi  = 1'b0;
        end else begin
            s.idx = CODE_W'(code % NREG_B);
            s.hi  = code[CODE_W-1];
        end
        return s;
    endfunction

    function automatic logic [1:0] disp_len(input logic [MODE_W-1:0] mode,
                                            input logic [CODE_W-1:0] rm);
        case (mode)
            MODE_DISP8:  return 2'd1;
            MODE_DISP16: return 2'd2;
            MODE_NODISP: return (rm == RM_DIRECT) ? 2'd2 : 2'd0;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/opdec_regsel.sv
module opdec_regsel
    import opdec_pkg::*;
(
    input  logic   dirs,
    input  logic   wide,
    input  logic   s_used,
    input  modrm_t mrm,
    output slot_t  src,
    output slot_t  dst,
    output logic   mem_op
);
    slot_t reg_slot;
    slot_t rm_slot;

    always_comb begin
        mem_op   = (mrm.mode != MODE_REG);
        reg_slot = map_code(mrm.regf, wide);
        rm_slot  = mem_op ? slot_t'('0) : map_code(mrm.rmf, wide);
        if (s_used) begin
            dst = rm_slot;
            src = '0;
        end else if (dirs) begin
            dst = reg_slot;
            src = rm_slot;
        end else begin
            dst = rm_slot;
            src = reg_slot;
        end
    end
endmodule

// File: rtl/opdec_ea.sv
module opdec_ea
    import opdec_pkg::*;
(
    input  modrm_t            mrm,
    input  logic [BYTE_W-1:0] disp_lo,
    input  logic [BYTE_W-1:0] disp_hi,
    input  logic [ADDR_W-1:0] bx_val,
    input  logic [ADDR_W-1:0] bp_val,
    input  logic [ADDR_W-1:0] si_val,
    input  logic [ADDR_W-1:0] di_val,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] index;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] wide_disp;

    always_comb begin
        wide_disp = {disp_hi, disp_lo};
        case (mrm.rmf)
            3'd0: begin base = bx_val; index = si_val; end
            3'd1: begin base = bx_val; index = di_val; end
            3'd2: begin base = bp_val; index = si_val; end
            3'd3: begin base = bp_val; index = di_val; end
            3'd4: begin base = '0;     index = si_val; end
            3'd5: begin base = '0;     index = di_val; end
            3'd6: begin base = bp_val; index = '0;     end
            default: begin base = bx_val; index = '0; end
        endcase
        case (mrm.mode)
            MODE_DISP8:  disp = {{EXT_W{disp_lo[BYTE_W-1]}}, disp_lo};
            MODE_DISP16: disp = wide_disp;
            default:     disp = '0;
        endcase
        if (mrm.mode == MODE_REG)
            ea = '0;
        else if (mrm.mode == MODE_NODISP && mrm.rmf == RM_DIRECT)
            ea = wide_disp;
        else
            ea = base + index + disp;
    end
endmodule

// File: rtl/opdec_len.sv
module opdec_len
    import opdec_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [CODE_W-1:0] rm,
    input  logic              sbit,
    input  logic              wide,
    input  logic              s_used,
    input  logic              imm_present,
    output logic [CNT_W-1:0]  count,
    output logic              bad,
    output logic              sext
);
    logic [1:0] dlen;
    logic [1:0] ilen;

    always_comb begin
        dlen = disp_len(mode, rm);
        if (!imm_present)
            ilen = 2'd0;
        else if (s_used)
            ilen = (!sbit && wide) ? 2'd2 : 2'd1;
        else
            ilen = wide ? 2'd2 : 2'd1;
        count = CNT_W'(dlen) + CNT_W'(ilen);
        bad   = s_used && sbit && !wide;
        sext  = s_used && sbit && wide;
    end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        modrm_byte,
    input  logic [7:0]        disp_lo,
    input  logic [7:0]        disp_hi,
    input  logic              s_used,
    input  logic              imm_present,
    input  logic [15:0]       bx_val,
    input  logic [15:0]       bp_val,
    input  logic [15:0]       si_val,
    input  logic [15:0]       di_val,
    output logic              out_valid,
    output logic [5:0]        out_opcode,
    output logic              op_wide,
    output logic [2:0]        src_idx,
    output logic              src_hi,
    output logic [2:0]        dst_idx,
    output logic              dst_hi,
    output logic              mem_operand,
    output logic [15:0]       eff_addr,
    output logic [2:0]        byte_count,
    output logic              bad_combo,
    output logic              imm_sext
);
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic              wide;
        slot_t             src;
        slot_t             dst;
        logic              mem;
        logic [ADDR_W-1:0] ea;
        logic [CNT_W-1:0]  cnt;
        logic              bad;
        logic              sext;
    } result_t;

    lead_t   lead;
    modrm_t  mrm;
    result_t nxt;
    result_t cur;
    logic    vld_q;

    assign lead = lead_t'(op_byte);
    assign mrm  = modrm_t'(modrm_byte);
    assign nxt.opc  = lead.opc;
    assign nxt.wide = lead.wide;

    opdec_regsel u_regsel (
        .dirs   (lead.dirs),
        .wide   (lead.wide),
        .s_used (s_used),
        .mrm    (mrm),
        .src    (nxt.src),
        .dst    (nxt.dst),
        .mem_op (nxt.mem)
    );

    opdec_ea u_ea (
        .mrm     (mrm),
        .disp_lo (disp_lo),
        .disp_hi (disp_hi),
        .bx_val  (bx_val),
        .bp_val  (bp_val),
        .si_val  (si_val),
        .di_val  (di_val),
        .ea      (nxt.ea)
    );

    opdec_len u_len (
        .mode        (mrm.mode),
        .rm          (mrm.rmf),
        .sbit        (lead.dirs),
        .wide        (lead.wide),
        .s_used      (s_used),
        .imm_present (imm_present),
        .count       (nxt.cnt),
        .bad         (nxt.bad),
        .sext        (nxt.sext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                cur <= nxt;
        end
    end

    assign out_valid   = vld_q;
    assign out_opcode  = cur.opc;
    assign op_wide     = cur.wide;
    assign src_idx     = cur.src.idx;
    assign src_hi      = cur.src.hi;
    assign dst_idx     = cur.dst.idx;
    assign dst_hi      = cur.dst.hi;
    assign mem_operand = cur.mem;
    assign eff_addr    = cur.ea;
    assign byte_count  = cur.cnt;
    assign bad_combo   = cur.bad;
    assign imm_sext    = cur.sext;
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  op_byte,
    input logic [7:0]  modrm_byte,
    input logic [7:0]  disp_lo,
    input logic [7:0]  disp_hi,
    input logic        s_used,
    input logic        out_valid,
    input logic        op_wide,
    input logic        src_hi,
    input logic        dst_hi,
    input logic        mem_operand,
    input logic [15:0] eff_addr,
    input logic [2:0]  byte_count,
    input logic        bad_combo
);
    p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(eff_addr) && $stable(byte_count)));
    p_word_no_high_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_wide) |-> (!src_hi && !dst_hi));
    p_regmode_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mem_operand) |-> (eff_addr == 16'h0000));
    p_direct_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && modrm_byte[7:6] == 2'b00 && modrm_byte[2:0] == 3'b110)
        |=> (eff_addr == {$past(disp_hi), $past(disp_lo)}));
    p_bad_combo_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && s_used && op_byte[1] && !op_byte[0]) |=> bad_combo);
    p_count_limit_r11: assert property (@(posedge clk) disable iff (rst)
        byte_count <= 3'd4);
endmodule

bind opdec_top opdec_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op_byte     (op_byte),
    .modrm_byte  (modrm_byte),
    .disp_lo     (disp_lo),
    .disp_hi     (disp_hi),
    .s_used      (s_used),
    .out_valid   (out_valid),
    .op_wide     (op_wide),
    .src_hi      (src_hi),
    .dst_hi      (dst_hi),
    .mem_operand (mem_operand),
    .eff_addr    (eff_addr),
    .byte_count  (byte_count),
    .bad_combo   (bad_combo)
);

// File: tb/test_opdec_top.sv
module test_opdec_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  op_byte = '0, modrm_byte = '0, disp_lo = '0, disp_hi = '0;
    logic        s_used = 1'b0, imm_present = 1'b0;
    logic [15:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
    logic        out_valid, op_wide, src_hi, dst_hi, mem_operand, bad_combo, imm_sext;
    logic [5:0]  out_opcode;
    logic [2:0]  src_idx, dst_idx, byte_count;
    logic [15:0] eff_addr;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        int vld, opc, wide, sidx, shi, didx, dhi, mem, ea, cnt, bad, sext;
        int md, rm, su;
    } exp_t;

    exp_t exp_r;

    opdec_top i_opdec_top (.*);

    always #(PERIOD/2) clk = ~clk;

    function automatic exp_t model(input int op, input int mrm, input int lo, input int hi,
                                   input int su, input int ip, input int b, input int bp,
                                   input int s, input int d);
        exp_t e;
        int w, dflag, rg, base, disp, rslot_i, rslot_h, mslot_i, mslot_h, ib, db;
        w = op % 2; dflag = (op / 2) % 2;
        e.md = mrm / 64; rg = (mrm / 8) % 8; e.rm = mrm % 8; e.su = su;
        e.vld = 1; e.opc = op / 4; e.wide = w;
        e.mem = (e.md != 3) ? 1 : 0;
        rslot_i = w ? rg : rg % 4;       rslot_h = w ? 0 : rg / 4;
        mslot_i = w ? e.rm : e.rm % 4;   mslot_h = w ? 0 : e.rm / 4;
        if (e.mem) begin mslot_i = 0; mslot_h = 0; end
        if (su) begin
            e.didx = mslot_i; e.dhi = mslot_h; e.sidx = 0; e.shi = 0;
        end else if (dflag) begin
            e.didx = rslot_i; e.dhi = rslot_h; e.sidx = mslot_i; e.shi = mslot_h;
        end else begin
            e.sidx = rslot_i; e.shi = rslot_h; e.didx = mslot_i; e.dhi = mslot_h;
        end
        case (e.rm)
            0: base = b + s;   1: base = b + d;
            2: base = bp + s;  3: base = bp + d;
            4: base = s;       5: base = d;
            6: base = bp;      default: base = b;
        endcase
        db = 0; disp = 0;
        if (e.md == 1) begin db = 1; disp = (lo >= 128) ? lo - 256 : lo; end
        if (e.md == 2) begin db = 2; disp = hi * 256 + lo; end
        if (e.md == 3)
            e.ea = 0;
        else if (e.md == 0 && e.rm == 6) begin
            db = 2; e.ea = hi * 256 + lo;
        end else
            e.ea = (base + disp) & 65535;
        if (!ip) ib = 0;
        else if (su) ib = (dflag == 0 && w == 1) ? 2 : 1;
        else ib = w ? 2 : 1;
        e.cnt = db + ib;
        e.bad  = (su && dflag && !w) ? 1 : 0;
        e.sext = (su && dflag && w) ? 1 : 0;
        return e;
    endfunction

    task automatic chk(input string tag, input string nm, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, expv);
        end
    endtask

    task automatic compare_all(input string base_tag);
        string eatag;
        string idtag;
        if (exp_r.md == 3) eatag = "R5";
        else if (exp_r.md == 0 && exp_r.rm == 6) eatag = "R8";
        else if (exp_r.md == 0) eatag = "R6";
        else eatag = "R7";
        idtag = exp_r.su ? "R9" : "R3";
        chk(base_tag == "" ? "R2" : base_tag, "out_valid", int'(out_valid), exp_r.vld);
        chk(base_tag == "" ? "R3" : base_tag, "opcode", int'(out_opcode), exp_r.opc);
        chk(base_tag == "" ? "R4" : base_tag, "op_wide", int'(op_wide), exp_r.wide);
        chk(base_tag == "" ? idtag : base_tag, "src_idx", int'(src_idx), exp_r.sidx);
        chk(base_tag == "" ? idtag : base_tag, "dst_idx", int'(dst_idx), exp_r.didx);
        chk(base_tag == "" ? "R4" : base_tag, "src_hi", int'(src_hi), exp_r.shi);
        chk(base_tag == "" ? "R4" : base_tag, "dst_hi", int'(dst_hi), exp_r.dhi);
        chk(base_tag == "" ? "R5" : base_tag, "mem_operand", int'(mem_operand), exp_r.mem);
        chk(base_tag == "" ? eatag : base_tag, "eff_addr", int'(eff_addr), exp_r.ea);
        chk(base_tag == "" ? "R11" : base_tag, "byte_count", int'(byte_count), exp_r.cnt);
        chk(base_tag == "" ? "R10" : base_tag, "bad_combo", int'(bad_combo), exp_r.bad);
        chk(base_tag == "" ? "R9" : base_tag, "imm_sext", int'(imm_sext), exp_r.sext);
    endtask

    task automatic apply(input bit v, input int op, input int mrm, input int lo, input int hi,
                         input bit su, input bit ip, input int b, input int bp,
                         input int s, input int d);
        @(negedge clk);
        in_valid = v; op_byte = 8'(op); modrm_byte = 8'(mrm);
        disp_lo = 8'(lo); disp_hi = 8'(hi); s_used = su; imm_present = ip;
        bx_val = 16'(b); bp_val = 16'(bp); si_val = 16'(s); di_val = 16'(d);
        @(posedge clk);
        #1;
        if (v) exp_r = model(op, mrm, lo, hi, int'(su), int'(ip), b, bp, s, d);
        exp_r.vld = int'(v);
        compare_all(v ? "" : "R2");
    endtask

    initial begin
        #(PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        exp_r = '{default: 0};
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");              // R1: zero during reset
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        compare_all("R1");              // R1: zero after reset, before a strobe
        // R3: D=1, register mode, word: dst=REG(BX=3), src=RM(SI=6)
        apply(1, 8'h8B, 8'hDE, 0, 0, 0, 0, 16'h1000, 16'h2000, 16'h0300, 16'h0040);
        // R3: D=0 swaps roles
        apply(1, 8'h89, 8'hDE, 0, 0, 0, 0, 16'h1000, 16'h2000, 16'h0300, 16'h0040);
        // R4: byte aliasing, REG=AH(100), RM=BH(111)
        apply(1, 8'h8A, 8'hE7, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6/R7: every R/M with a negative short displacement
        for (int r = 0; r < 8; r++)
            apply(1, 8'h8B, 8'h48 + r, 8'hF0, 8'h00, 0, 0, 16'h1000, 16'h2000, 16'h0300, 16'h0040);
        // R7: long displacement, R6 without displacement
        for (int r = 0; r < 8; r++)
            apply(1, 8'h03, 8'h80 + r, 8'h34, 8'h12, 0, 0, 16'h1000, 16'h2000, 16'h0300, 16'h0040);
        for (int r = 0; r < 8; r++)
            apply(1, 8'h03, 8'h10 + r, 8'h34, 8'h12, 0, 0, 16'h1000, 16'h2000, 16'h0300, 16'h0040);
        // R6: wrap-around of BX+SI+disp
        apply(1, 8'h8B, 8'h80, 8'h10, 8'h00, 0, 0, 16'hFFFF, 0, 16'h0002, 0);
        // R8: direct address
        apply(1, 8'h8B, 8'h06, 8'hCD, 8'hAB, 0, 1, 16'h1111, 16'h2222, 0, 0);
        // R9/R10/R11: sign/width combinations with immediate
        apply(1, 8'h80, 8'hC3, 0, 0, 1, 1, 0, 0, 0, 0);
        apply(1, 8'h81, 8'hC3, 0, 0, 1, 1, 0, 0, 0, 0);
        apply(1, 8'h83, 8'hC3, 0, 0, 1, 1, 0, 0, 0, 0);
        apply(1, 8'h82, 8'hC4, 0, 0, 1, 1, 0, 0, 0, 0);
        apply(1, 8'h83, 8'h46, 8'h80, 0, 1, 1, 0, 16'h0100, 0, 0);
        // R2: no strobe, changing inputs must not move outputs
        apply(0, 8'hFF, 8'h80, 8'h55, 8'h66, 0, 1, 16'h7777, 0, 0, 0);
        apply(0, 8'h00, 8'h06, 8'h01, 8'h02, 1, 0, 0, 0, 0, 0);
        // mixed stream
        for (int i = 0; i < 600; i++)
            apply(($urandom % 4) != 0, int'($urandom % 256), int'($urandom % 256),
                  int'($urandom % 256), int'($urandom % 256), 1'($urandom % 2),
                  1'($urandom % 2), int'($urandom % 65536), int'($urandom % 65536),
                  int'($urandom % 65536), int'($urandom % 65536));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule